// File: doc/BRIEF.md
# SPI Flash Data Buffer Serializer

This block is the data store and data-phase shifter of a serial flash controller. Software sees a 64-byte buffer as sixteen 32-bit words, addressed by word index, that it can read and write while no transfer runs. A cycle sequencer starts a data phase by pulsing a start line together with a byte count. The block then streams the counted bytes onto MOSI and captures MISO at the same time, in full duplex. Each received bit overwrites, in place, the bit that was just sent. When the phase ends the buffer holds the received data, and a one-cycle done pulse is returned to the sequencer.

The serial stream is little-endian by byte and most-significant-bit first within each byte. Buffer byte 0 is always the first byte on the wire, whatever the flash address. A shared clock-enable tick paces the serial clock: each tick marks one half period. The serial clock idles low, MOSI is updated on its falling edge and MISO is sampled on its rising edge.

Top module: `flash_xfer_buffer`

## Requirements
- R1: After reset every buffer word reads 0x00000000, and seq_done, xfer_busy and sck are low.
- R2: While xfer_busy is low, a write with reg_wr_en stores reg_wdata into word reg_addr. reg_rdata always shows the word selected by reg_addr, with buffer byte 4w+j in bits 8j+7..8j of word w.
- R3: Serial bit k of a transfer (k = 0 first) is bit 7-(k mod 8) of buffer byte k/8. Within word w the wire order is therefore bits 7..0, then 15..8, then 23..16, then 31..24, and bit 24 is last.
- R4: The MISO value sampled for serial bit k replaces that same buffer bit. After a transfer of n bytes, bytes 0..n-1 hold the received data and bytes n..63 are unchanged.
- R5: A byte count n from 1 to 64 produces exactly 8n rising sck edges. Counts above 64 are treated as 64.
- R6: sck is low whenever no transfer is active. sck changes only in the cycle after a clock where sck_tick is high. MOSI stays stable while sck is high. MISO is sampled on the rising sck step.
- R7: seq_done is high for exactly one cycle, on the cycle after the final falling sck step. xfer_busy falls in the same cycle.
- R8: A register write while xfer_busy is high is ignored. A read during a transfer returns the live, partly shifted contents.
- R9: A start request while xfer_busy is high is ignored and does not change the current transfer's length.
- R10: A start with byte count 0 gives a seq_done pulse on the next cycle, with xfer_busy staying low and no sck activity.
- R11: While idle, with no register write and no start, the buffer contents do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Word index for register read and write |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Word selected by reg_addr |
| seq_start | input | 1 | Start pulse from the cycle sequencer |
| seq_byte_cnt | input | 7 | Number of data bytes to shift |
| seq_done | output | 1 | One-cycle completion pulse |
| xfer_busy | output | 1 | Data phase in progress |
| sck_tick | input | 1 | Half-period enable for the serial clock |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions check on every cycle that the serial clock rests low when idle, moves only after a tick, and that MOSI holds while the clock is high. They also check that busy ends only with a single-cycle done pulse and that an idle buffer with no write or start stays frozen. The bench's scenarios are the only place where the wire bit order, the in-place replacement of sent bits by received bits, the exact edge count for every byte count from 1 to 64, and the clamp above 64 are shown. The same holds for ignored writes and starts during a transfer and for live reads part-way through it.

// File: rtl/fxb_pkg.sv
package fxb_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic {
        XS_IDLE,
        XS_SHIFT
    } xfer_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_evt_t;

    // Serial index k maps to flat buffer bit k with the in-byte position reversed.
    function automatic logic [2:0] lane_flip(input logic [2:0] k);
        return ~k;
    endfunction

endpackage

// File: rtl/fxb_store.sv
module fxb_store
    import fxb_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    localparam int AW    = $clog2(NUM_WORDS),
    localparam int NBITS = NUM_WORDS * WORD_W,
    localparam int IW    = $clog2(NBITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  logic [AW-1:0]     sw_addr,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] sw_rdata,
    input  logic              cap_en,
    input  logic [IW-1:0]     cap_idx,
    input  logic              cap_val,
    input  logic [IW-1:0]     peek_idx,
    output logic              peek_bit,
    output logic [NBITS-1:0]  image
);

    logic [NBITS-1:0]  bits_q;
    logic [WORD_W-1:0] words [NUM_WORDS];
    logic [IW-1:0]     cap_flat;
    logic [IW-1:0]     peek_flat;

    assign cap_flat  = {cap_idx[IW-1:3],  lane_flip(cap_idx[2:0])};
    assign peek_flat = {peek_idx[IW-1:3], lane_flip(peek_idx[2:0])};

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else begin
            if (sw_we) begin
                bits_q[{sw_addr, 5'b00000} +: WORD_W] <= sw_wdata;
            end
            if (cap_en) begin
                bits_q[cap_flat] <= cap_val;
            end
        end
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign words[w] = bits_q[w*WORD_W +: WORD_W];
    end

    assign sw_rdata = words[sw_addr];
    assign peek_bit = bits_q[peek_flat];
    assign image    = bits_q;

endmodule

// File: rtl/fxb_shift_ctrl.sv
module fxb_shift_ctrl
    import fxb_pkg::*;
#(
    parameter int NBYTES = 64,
    localparam int CW = $clog2(NBYTES + 1),
    localparam int IW = $clog2(NBYTES * BYTE_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] byte_cnt,
    input  logic          tick,
    input  logic          peek_bit,
    output logic [IW-1:0] peek_idx,
    output logic          cap_en,
    output logic [IW-1:0] cap_idx,
    output logic          busy,
    output logic          done,
    output logic          sck,
    output logic          mosi
);

    xfer_state_e   state_q;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] last_q;
    logic          sck_q;
    logic          done_q;
    logic          mosi_q;
    sck_evt_t      evt;
    logic [CW-1:0] eff_cnt;
    logic [CW+2:0] nbits;
    logic [IW-1:0] last_next;

    assign eff_cnt   = (byte_cnt > CW'(NBYTES)) ? CW'(NBYTES) : byte_cnt;
    assign nbits     = {eff_cnt, 3'b000};
    assign last_next = IW'(nbits - (CW+3)'(1));

    assign evt.rise = (state_q == XS_SHIFT) && tick && !sck_q;
    assign evt.fall = (state_q == XS_SHIFT) && tick && sck_q;

    assign peek_idx = (state_q == XS_IDLE) ? '0 : idx_q + IW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
            idx_q   <= '0;
            last_q  <= '0;
            sck_q   <= 1'b0;
            done_q  <= 1'b0;
            mosi_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                XS_IDLE: begin
                    if (start) begin
                        if (eff_cnt == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= XS_SHIFT;
                            idx_q   <= '0;
                            last_q  <= last_next;
                            sck_q   <= 1'b0;
                            mosi_q  <= peek_bit;
                        end
                    end
                end
                XS_SHIFT: begin
                    if (evt.fall) begin
                        sck_q <= 1'b0;
                        if (idx_q == last_q) begin
                            state_q <= XS_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q  <= idx_q + IW'(1);
                            mosi_q <= peek_bit;
                        end
                    end else if (evt.rise) begin
                        sck_q <= 1'b1;
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    assign cap_en  = evt.rise;
    assign cap_idx = idx_q;
    assign busy    = (state_q == XS_SHIFT);
    assign done    = done_q;
    assign sck     = sck_q;
    assign mosi    = mosi_q;

endmodule

// File: rtl/flash_xfer_buffer.sv
module flash_xfer_buffer
    import fxb_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    localparam int AW     = $clog2(NUM_WORDS),
    localparam int NBYTES = NUM_WORDS * (WORD_W / BYTE_W),
    localparam int CW     = $clog2(NBYTES + 1),
    localparam int NBITS  = NUM_WORDS * WORD_W,
    localparam int IW     = $clog2(NBITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_wr_en,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              seq_start,
    input  logic [CW-1:0]     seq_byte_cnt,
    output logic              seq_done,
    output logic              xfer_busy,
    input  logic              sck_tick,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);

    logic             busy_w;
    logic             cap_en;
    logic [IW-1:0]    cap_idx;
    logic [IW-1:0]    peek_idx;
    logic             peek_bit;
    logic [NBITS-1:0] buf_image;

    fxb_store #(
        .NUM_WORDS (NUM_WORDS)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (reg_wr_en && !busy_w),
        .sw_addr  (reg_addr),
        .sw_wdata (reg_wdata),
        .sw_rdata (reg_rdata),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .cap_val  (miso),
        .peek_idx (peek_idx),
        .peek_bit (peek_bit),
        .image    (buf_image)
    );

    fxb_shift_ctrl #(
        .NBYTES (NBYTES)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (seq_start),
        .byte_cnt (seq_byte_cnt),
        .tick     (sck_tick),
        .peek_bit (peek_bit),
        .peek_idx (peek_idx),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .busy     (busy_w),
        .done     (seq_done),
        .sck      (sck),
        .mosi     (mosi)
    );

    assign xfer_busy = busy_w;

endmodule

// File: rtl/fxb_checker.sv
module fxb_checker #(
    parameter int NBITS = 512
) (
    input logic             clk,
    input logic             rst,
    input logic             sck_tick,
    input logic             seq_start,
    input logic             reg_wr_en,
    input logic             seq_done,
    input logic             xfer_busy,
    input logic             sck,
    input logic             mosi,
    input logic [NBITS-1:0] buf_image
);

    p_idle_sck_low_r6: assert property (@(posedge clk) disable iff (rst)
        !xfer_busy |-> !sck);

    p_sck_moves_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        !sck_tick |=> $stable(sck));

    p_mosi_hold_high_r6: assert property (@(posedge clk) disable iff (rst)
        (sck && !sck_tick) |=> $stable(mosi));

    p_busy_ends_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(xfer_busy) |-> seq_done);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        (seq_done && !seq_start) |=> !seq_done);

    p_idle_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        (!xfer_busy && !reg_wr_en && !seq_start) |=> $stable(buf_image));

endmodule

bind flash_xfer_buffer fxb_checker #(
    .NBITS (NBITS)
) u_fxb_chk (
    .clk       (clk),
    .rst       (rst),
    .sck_tick  (sck_tick),
    .seq_start (seq_start),
    .reg_wr_en (reg_wr_en),
    .seq_done  (seq_done),
    .xfer_busy (xfer_busy),
    .sck       (sck),
    .mosi      (mosi),
    .buf_image (buf_image)
);

// File: tb/test_flash_xfer_buffer.sv
module test_flash_xfer_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 16;
    localparam int NB = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        seq_start = 1'b0;
    logic [6:0]  seq_byte_cnt = '0;
    logic        seq_done;
    logic        xfer_busy;
    logic        sck_tick = 1'b0;
    logic        sck;
    logic        mosi;
    logic        miso = 1'b0;

    int checks = 0;
    int fails  = 0;

    flash_xfer_buffer i_flash_xfer_buffer (
        .clk          (clk),
        .rst          (rst),
        .reg_addr     (reg_addr),
        .reg_wr_en    (reg_wr_en),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .seq_start    (seq_start),
        .seq_byte_cnt (seq_byte_cnt),
        .seq_done     (seq_done),
        .xfer_busy    (xfer_busy),
        .sck_tick     (sck_tick),
        .sck          (sck),
        .mosi         (mosi),
        .miso         (miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            sck_tick = ~sck_tick;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] tx_b(input int seed, input int b);
        return 8'((b * 37 + seed * 11 + 5));
    endfunction

    function automatic logic [7:0] rx_b(input int seed, input int b);
        return 8'((b * 91 + seed * 7 + 60)) ^ 8'hA5;
    endfunction

    function automatic logic [31:0] tx_word(input int seed, input int w);
        logic [31:0] v;
        for (int l = 0; l < 4; l++) v[l*8 +: 8] = tx_b(seed, 4*w + l);
        return v;
    endfunction

    function automatic logic [31:0] exp_word(input int seed, input int w, input int n);
        logic [31:0] v;
        for (int l = 0; l < 4; l++) begin
            int b = 4*w + l;
            v[l*8 +: 8] = (b < n) ? rx_b(seed, b) : tx_b(seed, b);
        end
        return v;
    endfunction

    function automatic logic rx_bit(input int seed, input int k);
        logic [7:0] t;
        t = rx_b(seed, k / 8);
        return t[7 - (k % 8)];
    endfunction

    function automatic logic tx_bit(input int seed, input int k);
        logic [7:0] t;
        t = tx_b(seed, k / 8);
        return t[7 - (k % 8)];
    endfunction

    task automatic wr_word(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = 4'(a);
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_word(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 v = reg_rdata;
    endtask

    task automatic run_xfer(input int seed, input int req_cnt, input bit intrude);
        int n;
        int rises;
        int bad;
        bit done_seen;
        logic prev_sck;
        logic [31:0] v;
        n = (req_cnt > NB) ? NB : req_cnt;
        for (int w = 0; w < NW; w++) wr_word(w, tx_word(seed, w));
        for (int w = 0; w < NW; w++) begin
            rd_word(w, v);
            chk(v == tx_word(seed, w), "R2", "idle write/readback", v, tx_word(seed, w));
        end
        reg_addr = '0;
        miso = rx_bit(seed, 0);
        @(negedge clk);
        seq_start    = 1'b1;
        seq_byte_cnt = 7'(req_cnt);
        rises = 0;
        bad = 0;
        done_seen = 0;
        prev_sck = 1'b0;
        while (!done_seen) begin
            @(negedge clk);
            seq_start = 1'b0;
            reg_wr_en = 1'b0;
            if (sck && !prev_sck) begin
                if (mosi !== tx_bit(seed, rises)) bad++;
                rises++;
                miso = (rises < 8*NB) ? rx_bit(seed, rises) : 1'b0;
                if (intrude && rises == 8) begin
                    #1;
                    chk(reg_rdata[7:0] == rx_b(seed, 0), "R8", "live read byte0",
                        {24'h0, reg_rdata[7:0]}, {24'h0, rx_b(seed, 0)});
                end
                if (intrude && rises == 9) begin
                    reg_addr     = 4'd15;
                    reg_wdata    = 32'hDEADBEEF;
                    reg_wr_en    = 1'b1;
                    seq_start    = 1'b1;
                    seq_byte_cnt = 7'd1;
                end
                if (intrude && rises == 10) begin
                    reg_addr  = 4'd0;
                    reg_wdata = 32'h12345678;
                    reg_wr_en = 1'b1;
                end
            end
            prev_sck = sck;
            if (seq_done) begin
                done_seen = 1;
                chk(!xfer_busy && !sck, "R7", "busy/sck low with done",
                    {30'h0, xfer_busy, sck}, 32'h0);
            end
        end
        @(negedge clk);
        chk(!seq_done, "R7", "done one cycle", {31'h0, seq_done}, 32'h0);
        chk(rises == 8*n, intrude ? "R9" : "R5", "sck rising count", rises, 8*n);
        chk(bad == 0, "R3", "mosi bit order mismatches", bad, 0);
        for (int w = 0; w < NW; w++) begin
            rd_word(w, v);
            chk(v == exp_word(seed, w, n), intrude ? "R8" : "R4", "buffer after transfer",
                v, exp_word(seed, w, n));
        end
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] snap [NW];
        bit sck_seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!seq_done && !xfer_busy && !sck, "R1", "control outputs after reset",
            {29'h0, seq_done, xfer_busy, sck}, 32'h0);
        for (int w = 0; w < NW; w++) begin
            rd_word(w, v);
            chk(v == 32'h0, "R1", "word after reset", v, 32'h0);
        end

        for (int n = 1; n <= NB; n++) run_xfer(n, n, 1'b0);

        run_xfer(101, 100, 1'b0);   // R5: count above 64 clamps to 64
        run_xfer(77, 127, 1'b0);    // R5: maximum code clamps to 64
        run_xfer(200, 8, 1'b1);     // R8/R9: write and start during transfer

        for (int w = 0; w < NW; w++) rd_word(w, snap[w]);
        @(negedge clk);
        seq_start    = 1'b1;
        seq_byte_cnt = 7'd0;
        @(negedge clk);
        seq_start = 1'b0;
        chk(seq_done && !xfer_busy, "R10", "zero count done next cycle",
            {30'h0, seq_done, xfer_busy}, 32'h2);
        @(negedge clk);
        chk(!seq_done, "R10", "zero count done single", {31'h0, seq_done}, 32'h0);
        sck_seen = 0;
        repeat (20) begin
            @(negedge clk);
            if (sck || xfer_busy) sck_seen = 1;
        end
        chk(!sck_seen, "R10", "no serial activity for zero count", {31'h0, sck_seen}, 32'h0);
        for (int w = 0; w < NW; w++) begin
            rd_word(w, v);
            chk(v == snap[w], "R11", "idle buffer unchanged", v, snap[w]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule